// File: doc/BRIEF.md
# Addressed Serial-Load Register Bank

This block receives control words over a three-wire serial link and keeps eight 8-bit output codes. Each word is 11 bits long and holds a 3-bit channel address followed by an 8-bit code. The word is shifted into a staging register. A load strobe then copies the code into the one output register that the address selects. An asynchronous active-low clear forces every output code to zero at once, without waiting for a clock.

All pins run without a clock relationship to the system clock. The serial clock, the second clock pin, the serial data and the load strobe each pass through a two-flop synchroniser, and their edges are found in the system clock domain. The second clock pin has two roles. While it is held low it enables shifting on the rising edge of the serial clock. When the serial clock is held high, its own falling edge shifts a bit. Each write also raises a one-cycle update pulse on the channel that received the code. The system clock must be fast enough that every minimum pin pulse width covers at least two of its cycles.

Top module: `serial_reg_bank`

## Requirements
- R1: While `rst` is high, and on the first sampling edge after it falls, every code in `code_o` is 0x00 and `upd_o` is all zero.
- R2: A word is 11 bits, sent in this order: address bit 2, address bit 1, address bit 0, then code bit 7 down to code bit 0. Address value k (0 to 7) selects channel k, which sits at `code_o[8k+7:8k]` and `upd_o[k]`.
- R3: A rising edge of `sclk_pin` while `sen_pin` is low shifts in the level of `sdi_pin`.
- R4: A falling edge of `sen_pin` while `sclk_pin` is high shifts in the level of `sdi_pin`.
- R5: No other pin activity shifts a bit. This covers a rising `sclk_pin` while `sen_pin` is high, a falling `sen_pin` while `sclk_pin` is low, and the falling edge of `sclk_pin` or the rising edge of `sen_pin`.
- R6: If more than 11 bits are shifted before a load, only the last 11 bits count.
- R7: A falling edge of `load_n_pin` writes the code field into the addressed channel. The other seven channels keep their codes.
- R8: Each write raises `upd_o[k]` for exactly one system clock cycle, for the written channel k only. At most one bit of `upd_o` is ever high.
- R9: While `clr_n_pin` is low, every code reads 0x00. The codes clear at once, with no system clock edge needed.
- R10: A load strobe that falls while `clr_n_pin` is low writes nothing and raises no update pulse. This also holds within two system cycles after clear is released.
- R11: Codes change only on a write or a clear. Shifting alone leaves `code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pin | input | 1 | Serial clock; shifts on a rising edge while sen_pin is low |
| sen_pin | input | 1 | Active-low shift enable, or a falling-edge shift clock while sclk_pin is high |
| sdi_pin | input | 1 | Serial data |
| load_n_pin | input | 1 | Active-low load strobe; its falling edge writes the addressed channel |
| clr_n_pin | input | 1 | Asynchronous active-low clear of all codes |
| code_o | output | 64 | Eight 8-bit codes; channel k at bits 8k+7:8k |
| upd_o | output | 8 | One-cycle write pulse per channel |

## Verification
A wrong bit in the staging register only shows at the ports when the next load happens. At that point the wrong channel or the wrong code gets written. The bench therefore compares all eight codes after every load, including loads that follow a few extra bits or pin activity that should shift nothing. A missed or doubled edge detection moves the address and code fields, so the error appears three system cycles after the load strobe falls. A fault in the clear path or the update pulse shows earlier: the codes stay nonzero while clear is low, or the number of pulses counted for a load is wrong.

// File: rtl/srb_pkg.sv
package srb_pkg;
  // Bit positions of the synchronised pin vector.
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_SEN  = 1;
  localparam int unsigned PIN_SDI  = 2;
  localparam int unsigned PIN_LDN  = 3;
  localparam int unsigned NPINS    = 4;
  // Idle levels: clock low, enable high, data low, load high.
  localparam logic [NPINS-1:0] PIN_IDLE = 4'b1010;
endpackage

// File: rtl/srb_pin_sync.sv
module srb_pin_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE[p]}};
      else     chain <= {chain[STAGES-2:0], pin_i[p]};
    end
    assign lvl_o[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/srb_clear_sync.sv
module srb_clear_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  output logic clr_ok
);
  logic [STAGES-1:0] q;
  // Goes low at once with the pin, and comes back STAGES cycles after release.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   q <= '0;
    else if (rst) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end
  assign clr_ok = q[STAGES-1];
endmodule

// File: rtl/srb_frame_shifter.sv
module srb_frame_shifter #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8,
  localparam int unsigned FW = AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_l,
  input  logic          sen_l,
  input  logic          sdi_l,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          sclk_p, sen_p;
  logic          shift_evt;
  logic [FW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b0;
      sen_p  <= 1'b1;
    end else begin
      sclk_p <= sclk_l;
      sen_p  <= sen_l;
    end
  end

  // Rising clock while enabled, or falling enable while clock is high.
  assign shift_evt = (sclk_l & ~sclk_p & ~sen_l) | (~sen_l & sen_p & sclk_l);

  always_ff @(posedge clk) begin
    if (rst)            sh <= '0;
    else if (shift_evt) sh <= {sh[FW-2:0], sdi_l};
  end

  assign addr_o = sh[FW-1:DW];
  assign data_o = sh[DW-1:0];

  assert_shift_R3_R4: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (sh[0] == $past(sdi_l)) && (sh[FW-1:1] == $past(sh[FW-2:0])));

  assert_no_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (sclk_l == sclk_p) && (sen_l == sen_p) |=> $stable(sh));
endmodule

// File: rtl/srb_code_bank.sv
module srb_code_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 8,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0]    upd_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(k));
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
        code_o[k*DW +: DW] <= '0;
        upd_o[k]           <= 1'b0;
      end else if (rst) begin
        code_o[k*DW +: DW] <= '0;
        upd_o[k]           <= 1'b0;
      end else begin
        upd_o[k] <= hit;
        if (hit) code_o[k*DW +: DW] <= wr_data;
      end
    end
  end

  assert_one_update_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_o));

  assert_write_R7: assert property (@(posedge clk) disable iff (rst || !clr_n)
    wr_en |=> (code_o[$past(wr_addr)*DW +: DW] == $past(wr_data))
              && (upd_o == (NCH'(1) << $past(wr_addr))));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !wr_en |=> $stable(code_o) && (upd_o == '0));

  assert_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (code_o == '0) && (upd_o == '0));
endmodule

// File: rtl/serial_reg_bank.sv
module serial_reg_bank #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2,
  localparam int unsigned AW    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_pin,
  input  logic              sen_pin,
  input  logic              sdi_pin,
  input  logic              load_n_pin,
  input  logic              clr_n_pin,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0]    upd_o
);
  import srb_pkg::*;

  logic [NPINS-1:0] pins, lvl;
  logic             ld_p, ld_evt, clr_ok;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    data;

  assign pins[PIN_SCLK] = sclk_pin;
  assign pins[PIN_SEN]  = sen_pin;
  assign pins[PIN_SDI]  = sdi_pin;
  assign pins[PIN_LDN]  = load_n_pin;

  srb_pin_sync #(.N(NPINS), .STAGES(STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pins), .lvl_o(lvl));

  srb_clear_sync #(.STAGES(STAGES)) u_clr (
    .clk(clk), .rst(rst), .clr_n(clr_n_pin), .clr_ok(clr_ok));

  srb_frame_shifter #(.AW(AW), .DW(DW)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_l(lvl[PIN_SCLK]), .sen_l(lvl[PIN_SEN]), .sdi_l(lvl[PIN_SDI]),
    .addr_o(addr), .data_o(data));

  always_ff @(posedge clk) begin
    if (rst) ld_p <= 1'b1;
    else     ld_p <= lvl[PIN_LDN];
  end

  // Falling load edge, dropped while clear is active or just released.
  assign ld_evt = ld_p & ~lvl[PIN_LDN] & clr_ok;

  srb_code_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .clr_n(clr_n_pin),
    .wr_en(ld_evt), .wr_addr(addr), .wr_data(data),
    .code_o(code_o), .upd_o(upd_o));

  assert_clear_blocks_load_R10: assert property (@(posedge clk) disable iff (rst)
    !clr_ok |=> (upd_o == '0));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (code_o == '0) && (upd_o == '0));
endmodule

// File: tb/tb_serial_reg_bank.sv
module tb_serial_reg_bank;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int H   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sen = 1'b1, sdi = 1'b0, ldn = 1'b1, clrn = 1'b1;
  logic [NCH*DW-1:0] code;
  logic [NCH-1:0]    upd;

  int checks = 0, fails = 0;
  logic [DW-1:0]  expc [NCH];
  logic [10:0]    mdl;
  int             pulse_cnt;
  logic [NCH-1:0] pulse_seen;

  always #2 clk = ~clk;

  serial_reg_bank dut (
    .clk(clk), .rst(rst), .sclk_pin(sclk), .sen_pin(sen), .sdi_pin(sdi),
    .load_n_pin(ldn), .clr_n_pin(clrn), .code_o(code), .upd_o(upd));

  always @(negedge clk) begin
    if (|upd) begin
      pulse_cnt++;
      pulse_seen |= upd;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [NCH*DW-1:0] exp_vec();
    logic [NCH*DW-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*DW +: DW] = expc[k];
    return v;
  endfunction

  task automatic check_codes(string req);
    check(code == exp_vec(), req, code, exp_vec());
  endtask

  // Shifting via rising serial clock with enable low (R3).
  task automatic bit_a(logic b);
    sen = 1'b0; tick(1); sdi = b; tick(H);
    sclk = 1'b1; tick(H); sclk = 1'b0; tick(1); sen = 1'b1; tick(H);
    mdl = {mdl[9:0], b};
  endtask

  // Shifting via falling enable with serial clock high (R4).
  task automatic bit_b(logic b);
    sclk = 1'b1; tick(1); sdi = b; tick(H);
    sen = 1'b0; tick(H); sen = 1'b1; tick(1); sclk = 1'b0; tick(H);
    mdl = {mdl[9:0], b};
  endtask

  // Pin activity that must not shift (R5).
  task automatic noop_pair(logic b);
    sdi = b; tick(H);
    sclk = 1'b1; tick(H); sclk = 1'b0; tick(H);
    sen = 1'b0; tick(H); sen = 1'b1; tick(H);
  endtask

  task automatic send_frame(logic [2:0] a, logic [7:0] d, int mode);
    logic [10:0] f;
    f = {a, d};
    for (int i = 10; i >= 0; i--) begin
      if (mode == 0 || (mode == 2 && $urandom_range(1) == 0)) bit_a(f[i]);
      else bit_b(f[i]);
    end
  endtask

  task automatic do_load(string req);
    pulse_cnt = 0; pulse_seen = '0;
    ldn = 1'b0; tick(H); ldn = 1'b1; tick(H + 2);
    expc[mdl[10:8]] = mdl[7:0];
    check_codes(req);
    check(pulse_cnt == 1 && pulse_seen == (NCH'(1) << mdl[10:8]),
          "R8 update pulse", 64'(pulse_seen) | (64'(pulse_cnt) << 32),
          64'(NCH'(1) << mdl[10:8]) | (64'd1 << 32));
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NCH; k++) expc[k] = '0;
    mdl = '0; pulse_cnt = 0; pulse_seen = '0;
    tick(5);
    check(code == '0 && upd == '0, "R1 reset during rst", code, 0);
    rst = 1'b0; tick(4);
    check(code == '0 && upd == '0, "R1 reset after rst", code, 0);

    // R2: every address in both shift modes, distinctive codes
    for (int a = 0; a < NCH; a++) begin
      send_frame(3'(a), 8'(8'hA0 + a), a % 2);
      do_load("R2 R7 address map");
    end

    // R5: activity that must not shift; the previous frame is reloaded
    send_frame(3'd5, 8'h3C, 0);
    for (int i = 0; i < 11; i++) noop_pair(~mdl[i % 11]);
    do_load("R5 no-shift activity ignored");
    check(code[5*DW +: DW] == 8'h3C, "R5 channel 5", code[5*DW +: DW], 8'h3C);

    // R6: extra leading bits are pushed out
    bit_a(1'b1); bit_b(1'b1); bit_a(1'b0);
    send_frame(3'd2, 8'h81, 2);
    do_load("R6 last eleven bits");

    // R11: shifting without load leaves codes alone
    send_frame(3'd7, 8'h00, 1);
    tick(4);
    check_codes("R11 no load no change");

    // R9: clear is immediate
    @(negedge clk); clrn = 1'b0; #1;
    for (int k = 0; k < NCH; k++) expc[k] = '0;
    check_codes("R9 immediate clear");
    // R10: load during clear is dropped
    pulse_cnt = 0;
    tick(2); ldn = 1'b0; tick(H); ldn = 1'b1; tick(H + 2);
    check(code == '0 && pulse_cnt == 0, "R10 load during clear", code, 0);
    clrn = 1'b1; tick(4);
    check_codes("R10 after clear release");

    // Directed extremes
    send_frame(3'd0, 8'hFF, 0); do_load("R7 all ones ch0");
    send_frame(3'd7, 8'h01, 1); do_load("R7 lsb ch7");

    // Random frames
    for (int n = 0; n < 150; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom_range(7));
      d = 8'($urandom_range(255));
      if ($urandom_range(4) == 0) bit_b(1'($urandom_range(1)));
      send_frame(a, d, int'($urandom_range(2)));
      if ($urandom_range(5) == 0) noop_pair(1'($urandom_range(1)));
      do_load("R7 random load");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule